// File: doc/BRIEF.md
# PCIe Root-Port Local Interrupt Aggregator

This block collects the interrupt events that a PCIe root port sees on its local side and merges them into one interrupt line for the host CPU. There are four legacy INTx event inputs and one MSI event input. A rising edge on any of them sets a sticky bit in a 32-bit pending word. A 32-bit enable word gates which pending bits may drive the interrupt line. Software reaches both words over a simple 32-bit register bus with word addressing.

The interrupt handler reads the pending word and runs the handler of each source whose bit is set. It then writes the value it read back to the pending word. Any bit written as one is cleared, so the pending word works as a write-one-to-clear register. A read of zero means no source is pending. At start-up, software writes zero to the enable word, which masks every source, and writes all ones to the pending word, which acknowledges every source. It then enables only the sources that have a handler.

Top module: `pirq_top`

## Requirements
- R1: The enable word is at byte offset 0x180 and the pending word at byte offset 0x184. On the word-addressed bus these are word 0x060 and word 0x061. A read of any other word returns zero, and a write to any other word changes neither register.
- R2: Legacy event pin n (n = 0 to 3) owns bit 24+n of both words. A rising edge on `intx_evt[n]` sets pending bit 24+n.
- R3: The MSI event owns bit 28 of both words. A rising edge on `msi_evt` sets pending bit 28.
- R4: Only a rising edge sets a pending bit. An input held high sets its bit once. After that bit is cleared, it stays clear for as long as the input remains high.
- R5: A write to the pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFFFFFF clears every pending bit.
- R6: If a rising edge and a write-one-clear hit the same pending bit on the same clock edge, the bit ends up set.
- R7: An enable bit of 1 lets its source through. `irq_out` is the OR over all bits of (pending AND enable), registered once. It therefore follows a change of the pending or enable word one clock later. Writing 0 to the enable word drops `irq_out`.
- R8: Pending bits latch whether or not the source is enabled. Enabling a source that is already pending raises `irq_out` one clock after the enable word is loaded.
- R9: Only bits 24 to 28 are implemented. All other bits of both words read as zero, and writes to them are ignored.
- R10: Reset clears the pending word, the enable word and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_evt | input | 4 | Legacy INTx event lines, pin n to pending bit 24+n |
| msi_evt | input | 1 | MSI event line, pending bit 28 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_sel` is high and `bus_wr` is low |
| irq_out | output | 1 | Registered interrupt line to the host |

## Verification
The hardest case to reach from the ports is a rising edge and a write-one-clear that land on the same pending bit at the same clock edge. The bench produces it by changing the event input and issuing the bus write in the same half-cycle before a single rising edge. The other difficult case is an input that stays high across a clear. The bench holds a legacy line high, clears its bit, and then reads the bit back over several cycles. This shows that the level alone never sets the bit again.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int unsigned REG_W = 32;

  typedef logic [REG_W-1:0] word_t;

  // Place the legacy event vector and the MSI event at their status bit positions.
  function automatic word_t place_events(input word_t legacy, input logic msi,
                                         input int unsigned nleg, input int unsigned lsb,
                                         input int unsigned msi_pos);
    word_t v;
    v = '0;
    for (int unsigned i = 0; i < nleg; i++) begin
      v[5'(lsb + i)] = legacy[5'(i)];
    end
    v[5'(msi_pos)] = msi;
    return v;
  endfunction

  // Set of implemented bit positions in both registers.
  function automatic word_t impl_bits(input int unsigned nleg, input int unsigned lsb,
                                      input int unsigned msi_pos);
    word_t v;
    v = '0;
    for (int unsigned i = 0; i < nleg; i++) begin
      v[5'(lsb + i)] = 1'b1;
    end
    v[5'(msi_pos)] = 1'b1;
    return v;
  endfunction

  // Pending-and-enabled reduction that feeds the interrupt line.
  function automatic logic any_enabled(input word_t status, input word_t enable);
    return |(status & enable);
  endfunction

  // Pending word next state: clear first, then set, so a set always wins.
  function automatic word_t status_next(input word_t cur, input word_t clr,
                                        input word_t set, input word_t impl);
    return ((cur & ~clr) | set) & impl;
  endfunction

endpackage

// File: rtl/pirq_edge.sv
module pirq_edge #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end

endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] MASK_WORD = 10'h060,
  parameter logic [ADDR_W-1:0] STAT_WORD = 10'h061,
  parameter word_t       IMPL      = 32'h1F00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  input  word_t             set_vec,
  output word_t             bus_rdata,
  output word_t             status_q,
  output word_t             mask_q,
  output word_t             clr_vec,
  output logic              mask_we
);

  logic  hit_mask, hit_stat, rd_en;
  word_t stat_d;

  assign hit_mask = (bus_addr == MASK_WORD);
  assign hit_stat = (bus_addr == STAT_WORD);
  assign rd_en    = bus_sel & ~bus_wr;
  assign mask_we  = bus_sel & bus_wr & hit_mask;
  assign clr_vec  = (bus_sel & bus_wr & hit_stat) ? (bus_wdata & IMPL) : '0;
  assign stat_d   = status_next(status_q, clr_vec, set_vec, IMPL);

  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (IMPL[g]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          status_q[g] <= 1'b0;
          mask_q[g]   <= 1'b0;
        end else begin
          status_q[g] <= stat_d[g];
          if (mask_we) mask_q[g] <= bus_wdata[g];
        end
      end
    end else begin : g_tie
      assign status_q[g] = 1'b0;
      assign mask_q[g]   = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en && hit_mask) bus_rdata = mask_q;
    if (rd_en && hit_stat) bus_rdata = status_q;
  end

endmodule

// File: rtl/pirq_line.sv
module pirq_line
  import pirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t status_q,
  input  word_t mask_q,
  output logic  irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_enabled(status_q, mask_q);
  end

endmodule

// File: rtl/pirq_top.sv
module pirq_top
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned NUM_LEGACY = 4,
  parameter int unsigned LEGACY_LSB = 24,
  parameter int unsigned MSI_POS    = 28,
  parameter int unsigned MASK_BYTE  = 32'h180,
  parameter int unsigned STAT_BYTE  = 32'h184
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEGACY-1:0] intx_evt,
  input  logic                  msi_evt,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq_out
);

  localparam int unsigned NSRC = NUM_LEGACY + 1;
  localparam word_t IMPL_BITS = impl_bits(NUM_LEGACY, LEGACY_LSB, MSI_POS);
  localparam logic [ADDR_W-1:0] MASK_WORD = ADDR_W'(MASK_BYTE >> 2);
  localparam logic [ADDR_W-1:0] STAT_WORD = ADDR_W'(STAT_BYTE >> 2);

  // Named internal events, brought out for the bound checker.
  logic [NSRC-1:0] src_lvl, src_rise;
  word_t set_vec, clr_vec, status_q, mask_q, impl_w;
  logic  mask_we;

  assign src_lvl = {msi_evt, intx_evt};
  assign impl_w  = IMPL_BITS;
  assign set_vec = place_events(word_t'(src_rise[NUM_LEGACY-1:0]), src_rise[NUM_LEGACY],
                                NUM_LEGACY, LEGACY_LSB, MSI_POS);

  pirq_edge #(.W(NSRC)) i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (src_lvl),
    .rise (src_rise)
  );

  pirq_regs #(
    .ADDR_W   (ADDR_W),
    .MASK_WORD(MASK_WORD),
    .STAT_WORD(STAT_WORD),
    .IMPL     (IMPL_BITS)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_vec  (set_vec),
    .bus_rdata(bus_rdata),
    .status_q (status_q),
    .mask_q   (mask_q),
    .clr_vec  (clr_vec),
    .mask_we  (mask_we)
  );

  pirq_line i_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .status_q(status_q),
    .mask_q  (mask_q),
    .irq_q   (irq_out)
  );

endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
  import pirq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input word_t status_q,
  input word_t mask_q,
  input word_t set_vec,
  input word_t clr_vec,
  input logic  mask_we,
  input word_t wdata,
  input word_t impl,
  input logic  irq
);

  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | mask_q) & ~impl) == '0);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

  p_set_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata & impl)));

  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((status_q & mask_q) != '0));

  p_irq_prompt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) != '0) |=> irq);

endmodule

bind pirq_top pirq_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .status_q(status_q),
  .mask_q  (mask_q),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .mask_we (mask_we),
  .wdata   (bus_wdata),
  .impl    (impl_w),
  .irq     (irq_out)
);

// File: tb/test_pirq_top.sv
module test_pirq_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] W_MASK = 10'h060;
  localparam logic [9:0] W_STAT = 10'h061;
  localparam logic [1:0] K_EV = 2'd0, K_WM = 2'd1, K_WS = 2'd2;
  localparam int NV = 14;

  // {kind, value, expected pending, expected enable, expected irq}
  // Event value: bits 3:0 legacy pins, bit 4 MSI. Pin n -> bit 24+n, MSI -> bit 28.
  localparam logic [98:0] VECS [NV] = '{
    {K_EV, 32'h0000_0001, 32'h0100_0000, 32'h0000_0000, 1'b0}, // R2 pin A
    {K_EV, 32'h0000_000A, 32'h0B00_0000, 32'h0000_0000, 1'b0}, // R2 pins B,D
    {K_EV, 32'h0000_0010, 32'h1B00_0000, 32'h0000_0000, 1'b0}, // R3 MSI masked
    {K_WM, 32'h0200_0000, 32'h1B00_0000, 32'h0200_0000, 1'b1}, // R8 unmask pending
    {K_WS, 32'h0200_0000, 32'h1900_0000, 32'h0200_0000, 1'b0}, // R5 clear one
    {K_WM, 32'hFFFF_FFFF, 32'h1900_0000, 32'h1F00_0000, 1'b1}, // R9 R7
    {K_WS, 32'h0000_0000, 32'h1900_0000, 32'h1F00_0000, 1'b1}, // R5 zeros keep
    {K_WS, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1F00_0000, 1'b0}, // R5 clear all
    {K_EV, 32'h0000_0004, 32'h0400_0000, 32'h1F00_0000, 1'b1}, // R2 pin C
    {K_WM, 32'h0000_0000, 32'h0400_0000, 32'h0000_0000, 1'b0}, // R7 mask all
    {K_WS, 32'hE0FF_FFFF, 32'h0400_0000, 32'h0000_0000, 1'b0}, // R9 unimpl write
    {K_WM, 32'h1000_0000, 32'h0400_0000, 32'h1000_0000, 1'b0}, // R7 MSI only
    {K_EV, 32'h0000_0010, 32'h1400_0000, 32'h1000_0000, 1'b1}, // R3 MSI enabled
    {K_WS, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1000_0000, 1'b0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_evt = '0;
  logic        msi_evt = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_top i_pirq_top (
    .clk(clk), .rst_n(rst_n), .intx_evt(intx_evt), .msi_evt(msi_evt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic drive_wr(input logic [9:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic release_all();
    bus_sel = 1'b0; bus_wr = 1'b0; intx_evt = '0; msi_evt = 1'b0;
  endtask

  // Inputs already driven at a falling edge: capture, release, let irq settle.
  task automatic finish_step();
    @(posedge clk); @(negedge clk);
    release_all();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R10: reset state
    rd(W_STAT, d); check("R10 pending after reset", d, 32'h0);
    rd(W_MASK, d); check("R10 enable after reset", d, 32'h0);
    check("R10 irq after reset", {31'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [31:0] v, es, em;
      logic        ei;
      {k, v, es, em, ei} = VECS[i];
      if (k == K_EV) begin
        intx_evt = v[3:0]; msi_evt = v[4];
      end else begin
        drive_wr((k == K_WM) ? W_MASK : W_STAT, v);
      end
      finish_step();
      rd(W_STAT, d); check($sformatf("table R2 R3 R5 R9 pending vec %0d", i), d, es);
      rd(W_MASK, d); check($sformatf("table R7 R9 enable vec %0d", i), d, em);
      check($sformatf("table R7 R8 irq vec %0d", i), {31'h0, irq_out}, {31'h0, ei});
    end

    // R4: level held high sets once, stays clear after clearing
    intx_evt = 4'b0001;
    @(posedge clk); @(negedge clk);
    rd(W_STAT, d); check("R4 level sets", d, 32'h0100_0000);
    drive_wr(W_STAT, 32'h0100_0000);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rd(W_STAT, d); check("R4 held level does not re-set", d, 32'h0);
    intx_evt = '0;
    @(negedge clk);

    // R6: edge and clear on the same bit at the same edge
    intx_evt = 4'b0010;
    drive_wr(W_STAT, 32'h0200_0000);
    finish_step();
    rd(W_STAT, d); check("R6 set wins over clear", d, 32'h0200_0000);
    drive_wr(W_STAT, 32'hFFFF_FFFF);
    finish_step();

    // R7/R8: one-cycle latency after enabling a pending source
    drive_wr(W_MASK, 32'h0);
    finish_step();
    intx_evt = 4'b0100;
    finish_step();
    drive_wr(W_MASK, 32'h0400_0000);
    @(posedge clk); @(negedge clk);
    release_all();
    check("R7 irq registered, not yet high", {31'h0, irq_out}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 irq after enabling pending source", {31'h0, irq_out}, 32'h1);

    // R1: other words read zero and ignore writes
    rd(10'h062, d); check("R1 unmapped word 0x062 reads zero", d, 32'h0);
    rd(10'h05F, d); check("R1 unmapped word 0x05F reads zero", d, 32'h0);
    drive_wr(10'h062, 32'hFFFF_FFFF);
    finish_step();
    rd(W_MASK, d); check("R1 stray write leaves enable", d, 32'h0400_0000);
    rd(W_STAT, d); check("R1 stray write leaves pending", d, 32'h0400_0000);

    // R10: reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(W_STAT, d); check("R10 pending cleared by reset", d, 32'h0);
    rd(W_MASK, d); check("R10 enable cleared by reset", d, 32'h0);
    check("R10 irq cleared by reset", {31'h0, irq_out}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule